// File: doc/BRIEF.md
# DDR2 Controller Initialisation Register Block

This block is the software-facing register front end of a DDR2 SDRAM controller. It sits on a simple 32-bit register bus and holds a configuration register, a status register, a bank of timing and error-correction settings, and a fixed revision word. It decodes a 4 KB window, and only full-width, word-aligned accesses are accepted.

Software brings the memory up with a one-shot handshake. It writes the status register with its start bit set. The block then drops the start bit, latches a sticky done flag and raises `mem_enable`. That output marks the point where the SDRAM address window becomes visible to the rest of the system. The handshake is held in a two-state machine:

- `INIT_IDLE`: memory is not yet enabled.
- `INIT_DONE`: memory is enabled.

It has one transition, `INIT_IDLE -> INIT_DONE`, taken on an accepted status write with bit 0 set. Reset places the machine in `INIT_DONE` when `boot_keep` is high and in `INIT_IDLE` when it is low. This lets an enable inherited from an earlier boot stage survive a reset.

Top module: `ddr2i_regblk`

## Requirements
- R1: Configuration register at offset 0x000. A write stores bits [15:0]; a read returns them with bits [31:16] as zero.
- R2: Status register at offset 0x004. A write stores bits [5:0] only. A read returns those bits, with bit 8 equal to the done state and every other bit zero. Software cannot change bit 8.
- R3: While not done, an accepted status write with bit 0 high stores bit 0 as 0, sets done and raises `mem_enable`. All three take effect on the clock edge that accepts the write.
- R4: Once done, done and `mem_enable` stay high until reset. A status write then stores bit 0 as written.
- R5: Offsets 0x008 to 0x04C (18 words) store and return all 32 bits written, each word independent of the others.
- R6: Offset 0x050 always reads 0x00000100. A write to it changes nothing and has no error.
- R7: Any other offset reads zero, ignores writes and raises `pslverr` for that transfer.
- R8: An access whose strobes are not 4'b1111, or whose address is not word aligned, raises `pslverr` and changes no state. A faulty read returns zero.
- R9: Reset clears every stored field to zero. After reset, done and `mem_enable` equal `boot_keep`, and a status read shows bit 8 accordingly.
- R10: `pready` is always high. Each cycle with `psel` high is one transfer. Its `prdata` and `pslverr` appear in the following cycle, and are zero for cycles with no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_keep | input | 1 | Keeps memory enabled through reset when high |
| psel | input | 1 | Transfer in this cycle |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; must be all ones |
| prdata | output | 32 | Registered read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Registered error response |
| mem_enable | output | 1 | SDRAM window visible |

## Verification
The assertions check these properties on every cycle:

- done stays set once it is set;
- the start bit reads back as zero on the cycle `mem_enable` rises;
- an error response carries zero data;
- configuration reads have a clear upper half;
- the revision word is constant;
- a status read's bit 8 matches the enable state at the access.

Only the bench's scenarios can show three further behaviours: that each timing word keeps its own value, that faulty or undefined accesses leave all state untouched, and that a reset with `boot_keep` high or low gives the right enable. The bench does this by replaying a random mix of accesses against a reference model and adding directed reset cases.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [0:0] {
        INIT_IDLE = 1'b0,
        INIT_DONE = 1'b1
    } init_state_e;

    typedef struct packed {
        logic cfg;
        logic stat;
        logic tim;
        logic rev;
        logic bad;
    } dec_s;
endpackage

// File: rtl/ddr2i_decode.sv
module ddr2i_decode
    import ddr2i_pkg::*;
#(
    parameter int unsigned NUM_TIM  = 18,
    parameter int unsigned CFG_OFF  = 'h000,
    parameter int unsigned STAT_OFF = 'h004,
    parameter int unsigned TIM_OFF  = 'h008,
    parameter int unsigned REV_OFF  = 'h050,
    localparam int unsigned IDX_W   = (NUM_TIM > 1) ? $clog2(NUM_TIM) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        strb,
    output dec_s              dec,
    output logic [IDX_W-1:0]  tim_idx
);
    localparam int unsigned TIM_LAST = TIM_OFF + 4 * (NUM_TIM - 1);

    logic              aligned;
    logic [ADDR_W-1:0] tim_rel;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        tim_rel  = addr - ADDR_W'(TIM_OFF);
        tim_idx  = tim_rel[IDX_W+1:2];
        dec.cfg  = aligned && (addr == ADDR_W'(CFG_OFF));
        dec.stat = aligned && (addr == ADDR_W'(STAT_OFF));
        dec.tim  = aligned && (addr >= ADDR_W'(TIM_OFF)) && (addr <= ADDR_W'(TIM_LAST));
        dec.rev  = aligned && (addr == ADDR_W'(REV_OFF));
        dec.bad  = !(dec.cfg || dec.stat || dec.tim || dec.rev) || (strb != 4'hF);
    end
endmodule

// File: rtl/ddr2i_init_fsm.sv
module ddr2i_init_fsm
    import ddr2i_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boot_keep,
    input  logic start_req,
    output logic done,
    output logic trig
);
    init_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= boot_keep ? INIT_DONE : INIT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INIT_IDLE: if (start_req) state_d = INIT_DONE;
            INIT_DONE: state_d = INIT_DONE;
        endcase
    end

    always_comb begin
        done = (state_q == INIT_DONE);
        trig = (state_q == INIT_IDLE) && start_req;
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R4
    AST_TRIG_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> done); // R3
endmodule

// File: rtl/ddr2i_regfile.sv
module ddr2i_regfile
    import ddr2i_pkg::*;
#(
    parameter int unsigned NUM_TIM = 18,
    parameter int unsigned CFG_W   = 16,
    parameter int unsigned STAT_W  = 6,
    localparam int unsigned IDX_W  = (NUM_TIM > 1) ? $clog2(NUM_TIM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic              wr_stat,
    input  logic              wr_tim,
    input  logic [IDX_W-1:0]  tim_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              trig,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [STAT_W-1:0] stat_q,
    output logic [DATA_W-1:0] tim_q [NUM_TIM]
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= wdata[CFG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stat_q <= '0;
        else if (wr_stat) stat_q <= {wdata[STAT_W-1:1], wdata[0] & ~trig};
    end

    for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                tim_q[g] <= '0;
            else if (wr_tim && (tim_idx == IDX_W'(g))) tim_q[g] <= wdata;
        end
    end
endmodule

// File: rtl/ddr2i_regblk.sv
module ddr2i_regblk
    import ddr2i_pkg::*;
#(
    parameter int unsigned NUM_TIM  = 18,
    parameter logic [31:0] REV_WORD = 32'h0000_0100,
    localparam int unsigned IDX_W   = (NUM_TIM > 1) ? $clog2(NUM_TIM) : 1,
    localparam int unsigned CFG_W   = 16,
    localparam int unsigned STAT_W  = 6,
    localparam int unsigned DONE_B  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_keep,
    input  logic              psel,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [3:0]        pstrb,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              mem_enable
);
    dec_s              dec;
    logic [IDX_W-1:0]  tim_idx;
    logic              wr_ok, rd_ok, done, trig;
    logic [CFG_W-1:0]  cfg_q;
    logic [STAT_W-1:0] stat_q;
    logic [DATA_W-1:0] tim_q [NUM_TIM];
    logic [DATA_W-1:0] rnext, prdata_q;
    logic              err_q;

    ddr2i_decode #(.NUM_TIM(NUM_TIM)) u_dec (
        .addr(paddr), .strb(pstrb), .dec(dec), .tim_idx(tim_idx)
    );

    assign wr_ok = psel && pwrite && !dec.bad;
    assign rd_ok = psel && !pwrite && !dec.bad;

    ddr2i_init_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .boot_keep(boot_keep),
        .start_req(wr_ok && dec.stat && pwdata[0]),
        .done(done), .trig(trig)
    );

    ddr2i_regfile #(.NUM_TIM(NUM_TIM), .CFG_W(CFG_W), .STAT_W(STAT_W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_cfg(wr_ok && dec.cfg), .wr_stat(wr_ok && dec.stat),
        .wr_tim(wr_ok && dec.tim), .tim_idx(tim_idx), .wdata(pwdata),
        .trig(trig), .cfg_q(cfg_q), .stat_q(stat_q), .tim_q(tim_q)
    );

    always_comb begin
        rnext = '0;
        if (dec.cfg)  rnext[CFG_W-1:0] = cfg_q;
        if (dec.stat) begin
            rnext[STAT_W-1:0] = stat_q;
            rnext[DONE_B]     = done;
        end
        if (dec.tim)  rnext = tim_q[tim_idx];
        if (dec.rev)  rnext = REV_WORD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prdata_q <= '0;
            err_q    <= 1'b0;
        end else begin
            prdata_q <= rd_ok ? rnext : '0;
            err_q    <= psel && dec.bad;
        end
    end

    assign prdata     = prdata_q;
    assign pslverr    = err_q;
    assign pready     = 1'b1;
    assign mem_enable = done;

    AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_ok && dec.cfg) |-> (prdata[31:16] == 16'h0)); // R1
    AST_STAT_DONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_ok && dec.stat) |-> (prdata[DONE_B] == $past(mem_enable))); // R2
    AST_START_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_enable) |-> (stat_q[0] == 1'b0)); // R3
    AST_REV_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_ok && dec.rev) |-> (prdata == REV_WORD)); // R6
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (prdata == '0)); // R7
endmodule

// File: tb/test_ddr2i_regblk.sv
module test_ddr2i_regblk;
    localparam int NT = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_keep = 1'b0;
    logic        psel = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = 4'hF;
    logic [31:0] prdata;
    logic        pready, pslverr, mem_enable;

    int checks = 0, fails = 0;

    // reference model
    logic [15:0] m_cfg;
    logic [5:0]  m_stat;
    logic        m_done;
    logic [31:0] m_tim [NT];

    always #4 clk = ~clk;

    ddr2i_regblk i_ddr2i_regblk (
        .clk(clk), .rst_n(rst_n), .boot_keep(boot_keep), .psel(psel),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
        .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .mem_enable(mem_enable)
    );

    function automatic bit f_bad(input logic [11:0] a, input logic [3:0] s);
        if (s != 4'hF || a[1:0] != 2'b00) return 1'b1;
        return !(a <= 12'h050);
    endfunction

    function automatic logic [31:0] f_read(input logic [11:0] a);
        if (a == 12'h000) return {16'h0, m_cfg};
        if (a == 12'h004) return {23'h0, m_done, 2'b00, m_stat};
        if (a == 12'h050) return 32'h0000_0100;
        if (a >= 12'h008 && a <= 12'h04C) return m_tim[(a - 12'h008) >> 2];
        return 32'h0;
    endfunction

    task automatic model_reset(input logic keep);
        m_cfg = '0; m_stat = '0; m_done = keep;
        for (int i = 0; i < NT; i++) m_tim[i] = '0;
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        if (a == 12'h000) m_cfg = d[15:0];
        else if (a == 12'h004) begin
            if (!m_done && d[0]) begin
                m_stat = {d[5:1], 1'b0};
                m_done = 1'b1;
            end else m_stat = d[5:0];
        end else if (a >= 12'h008 && a <= 12'h04C) m_tim[(a - 12'h008) >> 2] = d;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One transfer; outputs sampled on the following negedge.
    task automatic xfer(input string req, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input logic [3:0] s);
        logic        bad;
        logic [31:0] exp;
        bad = f_bad(a, s);
        exp = (!w && !bad) ? f_read(a) : 32'h0;
        @(negedge clk);
        psel = 1'b1; pwrite = w; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk);
        psel = 1'b0;
        if (w && !bad) model_write(a, d);
        chk({req, " err"}, {31'h0, pslverr}, {31'h0, bad});
        chk({req, " data"}, prdata, exp);
        chk({req, " enable"}, {31'h0, mem_enable}, {31'h0, m_done});
        chk("R10 ready", {31'h0, pready}, 32'h1);
    endtask

    task automatic do_reset(input logic keep);
        @(negedge clk);
        boot_keep = keep; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset(keep);
        @(negedge clk);
        chk("R9 reset enable", {31'h0, mem_enable}, {31'h0, keep});
        chk("R9 reset data", prdata, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset(1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 initial enable", {31'h0, mem_enable}, 32'h0);
        chk("R10 idle err", {31'h0, pslverr}, 32'h0);

        xfer("R1 cfg write", 1'b1, 12'h000, 32'hDEAD_BEEF, 4'hF);
        xfer("R1 cfg read", 1'b0, 12'h000, 32'h0, 4'hF);
        xfer("R2 stat write", 1'b1, 12'h004, 32'hFFFF_FF3E, 4'hF);
        xfer("R2 stat read", 1'b0, 12'h004, 32'h0, 4'hF);
        xfer("R8 bad strobe", 1'b1, 12'h004, 32'h1, 4'h7);
        xfer("R8 unaligned", 1'b1, 12'h006, 32'h1, 4'hF);
        xfer("R8 after faults", 1'b0, 12'h004, 32'h0, 4'hF);
        xfer("R3 trigger", 1'b1, 12'h004, 32'h0000_0021, 4'hF);
        xfer("R3 start clear", 1'b0, 12'h004, 32'h0, 4'hF);
        xfer("R4 rewrite start", 1'b1, 12'h004, 32'h0000_0001, 4'hF);
        xfer("R4 bit0 kept", 1'b0, 12'h004, 32'h0, 4'hF);
        xfer("R5 first", 1'b1, 12'h008, 32'h1234_5678, 4'hF);
        xfer("R5 last", 1'b1, 12'h04C, 32'h8765_4321, 4'hF);
        xfer("R5 first rd", 1'b0, 12'h008, 32'h0, 4'hF);
        xfer("R5 last rd", 1'b0, 12'h04C, 32'h0, 4'hF);
        xfer("R6 rev write", 1'b1, 12'h050, 32'hFFFF_FFFF, 4'hF);
        xfer("R6 rev read", 1'b0, 12'h050, 32'h0, 4'hF);
        xfer("R7 undef write", 1'b1, 12'h054, 32'hFFFF_FFFF, 4'hF);
        xfer("R7 undef read", 1'b0, 12'hFFC, 32'h0, 4'hF);

        do_reset(1'b1);
        xfer("R9 kept done", 1'b0, 12'h004, 32'h0, 4'hF);
        xfer("R9 cfg cleared", 1'b0, 12'h000, 32'h0, 4'hF);
        do_reset(1'b0);
        xfer("R9 done clear", 1'b0, 12'h004, 32'h0, 4'hF);

        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            logic [3:0]  s;
            a = ($urandom % 8 == 0) ? 12'($urandom) : 12'(($urandom % 24) * 4);
            s = ($urandom % 6 == 0) ? 4'($urandom) : 4'hF;
            if (n == 300) do_reset(1'b0);
            xfer("R10 random", 1'($urandom), a, $urandom, s);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule